// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block forms the linear address for a memory reference from a segment selection and an instruction offset. It keeps a shadow copy of six segment registers, each with a base, a limit and a present bit, and runs in one of two modes. In legacy mode every segment contributes its base and is checked against its limit and present bit, with the sum wrapping at 32 bits. In long mode the base and limit of the code, stack and two data segments are ignored. The stack and data segments still check their present bit. The two extra segments add a full 64-bit base.

A request names a default segment and may carry an explicit override that forces one of the two extra segments. The result is registered once. It appears on the cycle after the request as a linear address, its split into a page number and an in-page offset, and either a valid flag or a fault flag. Segment shadows are filled through a descriptor load port. The 64-bit bases of the two extra segments can also be written through a privileged port. That write is honoured only at privilege level 0; at any other level the write is refused and flagged.

Top module: `seg_lin_addr_gen`

## Requirements
- R1: Reset clears every base, limit and present bit to zero, selects legacy mode and drives `lin_valid`, `lin_fault` and `priv_viol` low. Until a descriptor is loaded, every request in legacy mode faults.
- R2: In legacy mode, a request through a present segment that is within its limit gives `lin_addr` = (base[31:0] + offset[31:0]) mod 2^32, with bits 63..32 zero. Offset bits 63..32 are ignored. The descriptor port loads a 32-bit base (zero-extended to 64 bits), a 32-bit limit and a present bit into the entry given by `desc_wr_idx`.
- R3: `page_off` equals `lin_addr[11:0]` and `page_idx` equals `lin_addr[63:12]`. In legacy mode, only the low 20 bits of `page_idx` can be nonzero.
- R4: In legacy mode, offset[31:0] greater than the selected limit raises `lin_fault` and keeps `lin_valid` low. An offset equal to the limit is accepted.
- R5: A segment whose present bit is 0 faults in legacy mode for every segment code. In long mode it faults only for codes 1, 2 and 3; for those codes base and limit are ignored and `lin_addr` equals the full offset.
- R6: In long mode, code 0 never faults and gives `lin_addr` equal to the 64-bit offset, whatever its base, limit and present bit hold.
- R7: In long mode, codes 4 and 5 give `lin_addr` = (64-bit base + offset) mod 2^64 with no limit or present check.
- R8: With `req_ovr_en` high, the segment used is code 4 when `req_ovr_gs` is 0 and code 5 when it is 1, and `req_dflt_seg` has no effect. With `req_ovr_en` low, `req_dflt_seg` is used.
- R9: A privileged base write with `cur_cpl` = 0 replaces the full 64-bit base of code 4 (`xbase_wr_gs` = 0) or code 5 (`xbase_wr_gs` = 1). The new base is used by any request made after the write cycle. In legacy mode only its low 32 bits are used.
- R10: A privileged base write with `cur_cpl` not 0 leaves both bases unchanged and raises `priv_viol` for exactly the one cycle after the write.
- R11: A request on one cycle gives, on the next cycle, exactly one of `lin_valid` and `lin_fault`. A cycle without a request gives neither on the next cycle.
- R12: Segment codes are 0 code, 1 stack, 2 data, 3 extra data, 4 and 5 the two base-programmable segments. Codes 6 and 7 fault in both modes. A mode write takes effect for requests after its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_en | input | 1 | Load the mode register |
| mode_wr_long | input | 1 | New mode: 1 long, 0 legacy |
| desc_wr_en | input | 1 | Load a segment shadow entry |
| desc_wr_idx | input | 3 | Segment code of the entry to load |
| desc_wr_base | input | 32 | Base to load (zero-extended) |
| desc_wr_limit | input | 32 | Limit to load |
| desc_wr_present | input | 1 | Present bit to load |
| xbase_wr_en | input | 1 | Privileged 64-bit base write strobe |
| xbase_wr_gs | input | 1 | Target: 0 code 4, 1 code 5 |
| xbase_wr_base | input | 64 | 64-bit base value |
| cur_cpl | input | 2 | Current privilege level |
| req_valid | input | 1 | Address request strobe |
| req_dflt_seg | input | 3 | Default segment code |
| req_ovr_en | input | 1 | Explicit override present |
| req_ovr_gs | input | 1 | Override target: 0 code 4, 1 code 5 |
| req_offset | input | 64 | Effective address / offset |
| lin_valid | output | 1 | Registered address is good |
| lin_fault | output | 1 | Registered request faulted |
| lin_addr | output | 64 | Registered linear address |
| page_idx | output | 52 | Page number part of `lin_addr` |
| page_off | output | 12 | In-page offset part of `lin_addr` |
| priv_viol | output | 1 | Refused privileged base write pulse |

## Verification
The assertions assume that the control inputs are never unknown while out of reset. They also assume that a request, a mode write and a descriptor load for the selected segment do not share a cycle, because the properties read the mode as it stands when the request is sampled. The bench follows this. It changes inputs only on the falling edge and issues each request, mode write and base write in a cycle of its own. It sweeps every segment code and override choice in both modes, against offsets placed on and around each limit and at values that wrap the sum.

// File: rtl/seg_agen_pkg.sv
package seg_agen_pkg;

    localparam int SEG_SEL_W = 3;
    localparam int SEG_COUNT = 6;

    typedef enum logic [SEG_SEL_W-1:0] {
        SEG_CS = 3'd0,
        SEG_SS = 3'd1,
        SEG_DS = 3'd2,
        SEG_ES = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_code_e;

    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_LONG   = 1'b1
    } agen_mode_e;

    // Override wins over the default; it can only name the two extra segments.
    function automatic logic [SEG_SEL_W-1:0] seg_pick(
        input logic                 ovr_en,
        input logic                 ovr_gs,
        input logic [SEG_SEL_W-1:0] dflt
    );
        if (ovr_en) begin
            return ovr_gs ? SEG_GS : SEG_FS;
        end
        return dflt;
    endfunction

endpackage

// File: rtl/seg_shadow_file.sv
module seg_shadow_file
    import seg_agen_pkg::*;
#(
    parameter int NUM_SEG = SEG_COUNT,
    parameter int BASE_W  = 64,
    parameter int DESC_W  = 32,
    parameter int CPL_W   = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             desc_wr_en,
    input  logic [SEG_SEL_W-1:0]             desc_wr_idx,
    input  logic [DESC_W-1:0]                desc_wr_base,
    input  logic [DESC_W-1:0]                desc_wr_limit,
    input  logic                             desc_wr_present,
    input  logic                             xbase_wr_en,
    input  logic                             xbase_wr_gs,
    input  logic [BASE_W-1:0]                xbase_wr_base,
    input  logic [CPL_W-1:0]                 cur_cpl,
    output logic [NUM_SEG-1:0][BASE_W-1:0]   base_o,
    output logic [NUM_SEG-1:0][DESC_W-1:0]   limit_o,
    output logic [NUM_SEG-1:0]               present_o,
    output logic                             priv_viol_o
);

    localparam int ZEXT_W = BASE_W - DESC_W;

    typedef struct packed {
        logic [NUM_SEG-1:0][BASE_W-1:0] base;
        logic [NUM_SEG-1:0][DESC_W-1:0] limit;
        logic [NUM_SEG-1:0]             present;
        logic                           viol;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.viol = 1'b0;

        if (desc_wr_en && (int'(desc_wr_idx) < NUM_SEG)) begin
            sh_d.base[desc_wr_idx]    = {{ZEXT_W{1'b0}}, desc_wr_base};
            sh_d.limit[desc_wr_idx]   = desc_wr_limit;
            sh_d.present[desc_wr_idx] = desc_wr_present;
        end

        // The privileged port is applied last, so it wins over a descriptor
        // load of the same entry in the same cycle.
        if (xbase_wr_en) begin
            if (cur_cpl == '0) begin
                if (xbase_wr_gs) begin
                    sh_d.base[SEG_GS] = xbase_wr_base;
                end else begin
                    sh_d.base[SEG_FS] = xbase_wr_base;
                end
            end else begin
                sh_d.viol = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign base_o      = sh_q.base;
    assign limit_o     = sh_q.limit;
    assign present_o   = sh_q.present;
    assign priv_viol_o = sh_q.viol;

endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
    import seg_agen_pkg::*;
#(
    parameter int NUM_SEG = SEG_COUNT,
    parameter int LIN_W   = 64,
    parameter int LEG_W   = 32
) (
    input  logic                            long_mode,
    input  logic [SEG_SEL_W-1:0]            sel,
    input  logic [LIN_W-1:0]                offset,
    input  logic [NUM_SEG-1:0][LIN_W-1:0]   base,
    input  logic [NUM_SEG-1:0][LEG_W-1:0]   limit,
    input  logic [NUM_SEG-1:0]              present,
    output logic [LIN_W-1:0]                lin_addr,
    output logic                            fault
);

    localparam int HI_W = LIN_W - LEG_W;

    logic [NUM_SEG-1:0][LIN_W-1:0] leg_sum;
    logic [NUM_SEG-1:0][LIN_W-1:0] long_sum;
    logic [NUM_SEG-1:0]            leg_flt;
    logic [NUM_SEG-1:0]            long_flt;

    // One address path per segment; the long-mode rule differs per code.
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        assign leg_sum[g] = {{HI_W{1'b0}}, base[g][LEG_W-1:0] + offset[LEG_W-1:0]};
        assign leg_flt[g] = !present[g] || (offset[LEG_W-1:0] > limit[g]);

        if (g == int'(SEG_FS) || g == int'(SEG_GS)) begin : g_wide
            assign long_sum[g] = base[g] + offset;
            assign long_flt[g] = 1'b0;
        end else if (g == int'(SEG_CS)) begin : g_flat
            logic unused_hi;
            assign unused_hi   = ^base[g][LIN_W-1:LEG_W];
            assign long_sum[g] = offset;
            assign long_flt[g] = 1'b0;
        end else begin : g_pres
            logic unused_hi;
            assign unused_hi   = ^base[g][LIN_W-1:LEG_W];
            assign long_sum[g] = offset;
            assign long_flt[g] = !present[g];
        end
    end

    always_comb begin
        lin_addr = '0;
        fault    = 1'b1;
        if (int'(sel) < NUM_SEG) begin
            if (long_mode) begin
                lin_addr = long_sum[sel];
                fault    = long_flt[sel];
            end else begin
                lin_addr = leg_sum[sel];
                fault    = leg_flt[sel];
            end
        end
    end

endmodule

// File: rtl/seg_lin_addr_gen.sv
module seg_lin_addr_gen
    import seg_agen_pkg::*;
#(
    parameter int LIN_W      = 64,
    parameter int LEG_W      = 32,
    parameter int PAGE_OFF_W = 12,
    parameter int CPL_W      = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_wr_en,
    input  logic                      mode_wr_long,
    input  logic                      desc_wr_en,
    input  logic [SEG_SEL_W-1:0]      desc_wr_idx,
    input  logic [LEG_W-1:0]          desc_wr_base,
    input  logic [LEG_W-1:0]          desc_wr_limit,
    input  logic                      desc_wr_present,
    input  logic                      xbase_wr_en,
    input  logic                      xbase_wr_gs,
    input  logic [LIN_W-1:0]          xbase_wr_base,
    input  logic [CPL_W-1:0]          cur_cpl,
    input  logic                      req_valid,
    input  logic [SEG_SEL_W-1:0]      req_dflt_seg,
    input  logic                      req_ovr_en,
    input  logic                      req_ovr_gs,
    input  logic [LIN_W-1:0]          req_offset,
    output logic                      lin_valid,
    output logic                      lin_fault,
    output logic [LIN_W-1:0]          lin_addr,
    output logic [LIN_W-PAGE_OFF_W-1:0] page_idx,
    output logic [PAGE_OFF_W-1:0]     page_off,
    output logic                      priv_viol
);

    localparam int NUM_SEG = SEG_COUNT;

    typedef struct packed {
        agen_mode_e       mode;
        logic             valid;
        logic             fault;
        logic [LIN_W-1:0] addr;
    } agen_state_t;

    agen_state_t st_d, st_q;

    logic [NUM_SEG-1:0][LIN_W-1:0] seg_base;
    logic [NUM_SEG-1:0][LEG_W-1:0] seg_limit;
    logic [NUM_SEG-1:0]            seg_present;
    logic [SEG_SEL_W-1:0]          sel_seg;
    logic [LIN_W-1:0]              calc_addr;
    logic                          calc_fault;
    logic                          long_mode_w;

    seg_shadow_file #(
        .NUM_SEG (NUM_SEG),
        .BASE_W  (LIN_W),
        .DESC_W  (LEG_W),
        .CPL_W   (CPL_W)
    ) u_shadow (
        .clk             (clk),
        .rst_n           (rst_n),
        .desc_wr_en      (desc_wr_en),
        .desc_wr_idx     (desc_wr_idx),
        .desc_wr_base    (desc_wr_base),
        .desc_wr_limit   (desc_wr_limit),
        .desc_wr_present (desc_wr_present),
        .xbase_wr_en     (xbase_wr_en),
        .xbase_wr_gs     (xbase_wr_gs),
        .xbase_wr_base   (xbase_wr_base),
        .cur_cpl         (cur_cpl),
        .base_o          (seg_base),
        .limit_o         (seg_limit),
        .present_o       (seg_present),
        .priv_viol_o     (priv_viol)
    );

    assign long_mode_w = (st_q.mode == MODE_LONG);
    assign sel_seg     = seg_pick(req_ovr_en, req_ovr_gs, req_dflt_seg);

    seg_addr_calc #(
        .NUM_SEG (NUM_SEG),
        .LIN_W   (LIN_W),
        .LEG_W   (LEG_W)
    ) u_calc (
        .long_mode (long_mode_w),
        .sel       (sel_seg),
        .offset    (req_offset),
        .base      (seg_base),
        .limit     (seg_limit),
        .present   (seg_present),
        .lin_addr  (calc_addr),
        .fault     (calc_fault)
    );

    always_comb begin
        st_d = st_q;
        if (mode_wr_en) begin
            st_d.mode = mode_wr_long ? MODE_LONG : MODE_LEGACY;
        end
        st_d.valid = req_valid && !calc_fault;
        st_d.fault = req_valid && calc_fault;
        if (req_valid) begin
            st_d.addr = calc_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lin_valid = st_q.valid;
    assign lin_fault = st_q.fault;
    assign lin_addr  = st_q.addr;
    assign page_idx  = st_q.addr[LIN_W-1:PAGE_OFF_W];
    assign page_off  = st_q.addr[PAGE_OFF_W-1:0];

endmodule

// File: rtl/seg_agen_chk.sv
module seg_agen_chk #(
    parameter int LIN_W = 64,
    parameter int LEG_W = 32,
    parameter int CPL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             long_mode,
    input logic             req_valid,
    input logic [2:0]       req_dflt_seg,
    input logic             req_ovr_en,
    input logic [LIN_W-1:0] req_offset,
    input logic             xbase_wr_en,
    input logic [CPL_W-1:0] cur_cpl,
    input logic             lin_valid,
    input logic             lin_fault,
    input logic [LIN_W-1:0] lin_addr,
    input logic             priv_viol
);

    // R11
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lin_valid && lin_fault));

    // R11
    req_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (lin_valid || lin_fault));

    // R11
    idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!lin_valid && !lin_fault));

    // R10
    priv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xbase_wr_en && cur_cpl != '0) |=> priv_viol);

    // R10
    priv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(xbase_wr_en && cur_cpl != '0) |=> !priv_viol);

    // R6
    long_flat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && long_mode && !req_ovr_en && req_dflt_seg == 3'd0)
        |=> (lin_valid && lin_addr == $past(req_offset)));

    // R2
    legacy_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !long_mode) |=> (lin_addr[LIN_W-1:LEG_W] == '0));

    // R12
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ovr_en && req_dflt_seg > 3'd5) |=> lin_fault);

endmodule

bind seg_lin_addr_gen seg_agen_chk #(
    .LIN_W (LIN_W),
    .LEG_W (LEG_W),
    .CPL_W (CPL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .long_mode    (long_mode_w),
    .req_valid    (req_valid),
    .req_dflt_seg (req_dflt_seg),
    .req_ovr_en   (req_ovr_en),
    .req_offset   (req_offset),
    .xbase_wr_en  (xbase_wr_en),
    .cur_cpl      (cur_cpl),
    .lin_valid    (lin_valid),
    .lin_fault    (lin_fault),
    .lin_addr     (lin_addr),
    .priv_viol    (priv_viol)
);

// File: tb/seg_lin_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_lin_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_wr_en, mode_wr_long;
    logic        desc_wr_en;
    logic [2:0]  desc_wr_idx;
    logic [31:0] desc_wr_base, desc_wr_limit;
    logic        desc_wr_present;
    logic        xbase_wr_en, xbase_wr_gs;
    logic [63:0] xbase_wr_base;
    logic [1:0]  cur_cpl;
    logic        req_valid;
    logic [2:0]  req_dflt_seg;
    logic        req_ovr_en, req_ovr_gs;
    logic [63:0] req_offset;
    logic        lin_valid, lin_fault;
    logic [63:0] lin_addr;
    logic [51:0] page_idx;
    logic [11:0] page_off;
    logic        priv_viol;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Bench-side model of the programmed state
    logic [63:0] m_base [0:5];
    logic [31:0] m_lim  [0:5];
    logic        m_pres [0:5];
    logic        m_long;
    logic [63:0] offs   [0:8];

    always #4 clk = ~clk;

    seg_lin_addr_gen u_seg_lin_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .mode_wr_en(mode_wr_en), .mode_wr_long(mode_wr_long),
        .desc_wr_en(desc_wr_en), .desc_wr_idx(desc_wr_idx),
        .desc_wr_base(desc_wr_base), .desc_wr_limit(desc_wr_limit),
        .desc_wr_present(desc_wr_present),
        .xbase_wr_en(xbase_wr_en), .xbase_wr_gs(xbase_wr_gs),
        .xbase_wr_base(xbase_wr_base), .cur_cpl(cur_cpl),
        .req_valid(req_valid), .req_dflt_seg(req_dflt_seg),
        .req_ovr_en(req_ovr_en), .req_ovr_gs(req_ovr_gs), .req_offset(req_offset),
        .lin_valid(lin_valid), .lin_fault(lin_fault), .lin_addr(lin_addr),
        .page_idx(page_idx), .page_off(page_off), .priv_viol(priv_viol)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input logic [2:0] d, input bit oe, input bit og,
                                  input logic [63:0] off, output logic ev,
                                  output logic ef, output logic [63:0] ea);
        int s;
        s  = oe ? (og ? 5 : 4) : int'(d);
        ea = 64'h0;
        ef = 1'b1;
        if (s <= 5) begin
            if (m_long) begin
                if (s == 0) begin
                    ea = off; ef = 1'b0;
                end else if (s >= 4) begin
                    ea = m_base[s] + off; ef = 1'b0;
                end else begin
                    ea = off; ef = !m_pres[s];
                end
            end else begin
                ea = {32'h0, m_base[s][31:0] + off[31:0]};
                ef = !m_pres[s] || (off[31:0] > m_lim[s]);
            end
        end
        ev = !ef;
    endfunction

    function automatic string tag_of(input logic [2:0] d, input bit oe, input logic [63:0] off);
        int s;
        s = int'(d);
        if (oe) return "R8";
        if (s > 5) return "R12";
        if (m_long) begin
            if (s == 0) return "R6";
            if (s >= 4) return "R7";
            return "R5";
        end
        if (!m_pres[s]) return "R5";
        if (off[31:0] > m_lim[s]) return "R4";
        return "R2";
    endfunction

    task automatic req_check(input logic [2:0] d, input bit oe, input bit og,
                             input logic [63:0] off);
        logic ev, ef;
        logic [63:0] ea;
        string t;
        model(d, oe, og, off, ev, ef, ea);
        t = tag_of(d, oe, off);
        @(negedge clk);
        req_valid = 1'b1; req_dflt_seg = d; req_ovr_en = oe; req_ovr_gs = og;
        req_offset = off;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(lin_valid === ev, t, "valid", {63'h0, lin_valid}, {63'h0, ev});
        chk(lin_fault === ef, t, "fault", {63'h0, lin_fault}, {63'h0, ef});
        if (ev) chk(lin_addr === ea, t, "addr", lin_addr, ea);
        // R3 page split
        chk({page_idx, page_off} === lin_addr, "R3", "page split",
            {page_idx, page_off}, lin_addr);
    endtask

    task automatic load_desc(input logic [2:0] idx, input logic [31:0] b,
                             input logic [31:0] l, input logic p);
        @(negedge clk);
        desc_wr_en = 1'b1; desc_wr_idx = idx; desc_wr_base = b;
        desc_wr_limit = l; desc_wr_present = p;
        @(posedge clk);
        @(negedge clk);
        desc_wr_en = 1'b0;
        m_base[idx] = {32'h0, b}; m_lim[idx] = l; m_pres[idx] = p;
    endtask

    task automatic set_mode(input logic lng);
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_long = lng;
        @(posedge clk);
        @(negedge clk);
        mode_wr_en = 1'b0;
        m_long = lng;
    endtask

    task automatic xbase_write(input bit gs, input logic [63:0] b, input logic [1:0] cpl);
        @(negedge clk);
        xbase_wr_en = 1'b1; xbase_wr_gs = gs; xbase_wr_base = b; cur_cpl = cpl;
        @(posedge clk);
        @(negedge clk);
        xbase_wr_en = 1'b0; cur_cpl = 2'd0;
        if (cpl == 2'd0) begin
            chk(priv_viol === 1'b0, "R9", "no violation at level 0",
                {63'h0, priv_viol}, 64'h0);
            m_base[gs ? 5 : 4] = b;
        end else begin
            chk(priv_viol === 1'b1, "R10", "violation pulse", {63'h0, priv_viol}, 64'h1);
        end
        @(posedge clk);
        @(negedge clk);
        chk(priv_viol === 1'b0, "R10", "pulse is one cycle", {63'h0, priv_viol}, 64'h0);
    endtask

    task automatic sweep();
        for (int s = 0; s < 8; s++) begin
            for (int o = 0; o < 3; o++) begin
                for (int k = 0; k < 9; k++) begin
                    req_check(3'(s), o != 0, o == 2, offs[k]);
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        mode_wr_en = 0; mode_wr_long = 0;
        desc_wr_en = 0; desc_wr_idx = 0; desc_wr_base = 0; desc_wr_limit = 0;
        desc_wr_present = 0;
        xbase_wr_en = 0; xbase_wr_gs = 0; xbase_wr_base = 0; cur_cpl = 0;
        req_valid = 0; req_dflt_seg = 0; req_ovr_en = 0; req_ovr_gs = 0; req_offset = 0;
        m_long = 1'b0;
        for (int i = 0; i < 6; i++) begin
            m_base[i] = 64'h0; m_lim[i] = 32'h0; m_pres[i] = 1'b0;
        end
        offs[0] = 64'h0;
        offs[1] = 64'h7FF;
        offs[2] = 64'h800;
        offs[3] = 64'hFFF;
        offs[4] = 64'h1000;
        offs[5] = 64'h2000;
        offs[6] = 64'hFFFF;
        offs[7] = 64'h1_0000;
        offs[8] = 64'hABCD_0000_0000_0123;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(lin_valid === 1'b0, "R1", "valid after reset", {63'h0, lin_valid}, 64'h0);
        chk(lin_fault === 1'b0, "R1", "fault after reset", {63'h0, lin_fault}, 64'h0);
        chk(priv_viol === 1'b0, "R1", "viol after reset", {63'h0, priv_viol}, 64'h0);
        chk(lin_addr === 64'h0, "R1", "addr after reset", lin_addr, 64'h0);
        rst_n = 1'b1;

        // R1: nothing present yet, every legacy request faults
        for (int s = 0; s < 6; s++) req_check(3'(s), 1'b0, 1'b0, 64'h10);

        // R11: an idle cycle leaves both flags low
        @(posedge clk);
        @(negedge clk);
        chk(!lin_valid && !lin_fault, "R11", "idle cycle",
            {62'h0, lin_valid, lin_fault}, 64'h0);

        load_desc(3'd0, 32'h0000_1000, 32'h0000_FFFF, 1'b1);
        load_desc(3'd1, 32'h0002_0000, 32'h0000_0FFF, 1'b1);
        load_desc(3'd2, 32'hFFFF_F000, 32'hFFFF_FFFF, 1'b1);
        load_desc(3'd3, 32'h0000_0300, 32'h0000_0010, 1'b0);
        load_desc(3'd4, 32'h4000_0000, 32'h0000_07FF, 1'b1);
        load_desc(3'd5, 32'h0000_5000, 32'h00FF_FFFF, 1'b1);
        // R12: codes 6 and 7 ignored by the descriptor port
        load_desc(3'd6, 32'h1234_5678, 32'hFFFF_FFFF, 1'b1);

        // Legacy sweep: R2, R4, R5, R8, R12
        sweep();

        // Long mode: R12 mode write, then R9 and R10 base writes
        set_mode(1'b1);
        xbase_write(1'b0, 64'hFFFF_FFFF_FFFF_F000, 2'd0);
        xbase_write(1'b1, 64'h0000_1234_0000_0000, 2'd0);
        for (int c = 1; c < 4; c++) begin
            xbase_write(c[0], 64'hDEAD_BEEF_0000_0000, 2'(c));
        end
        // Long sweep: R5, R6, R7, R8, R12; refused writes leave bases as modelled (R10)
        sweep();
        req_check(3'd5, 1'b0, 1'b0, 64'h0); // R10 base of code 5 unchanged

        // Back to legacy: only low 32 bits of a wide base are used (R9)
        set_mode(1'b0);
        req_check(3'd4, 1'b0, 1'b0, 64'h2000);
        req_check(3'd5, 1'b1, 1'b1, 64'h100);
        // A descriptor load replaces the wide base with a zero-extended one (R2)
        load_desc(3'd4, 32'h0000_8000, 32'h0000_FFFF, 1'b1);
        set_mode(1'b1);
        req_check(3'd0, 1'b1, 1'b0, 64'hFFFF_0000_0000_0001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule